// File: doc/BRIEF.md
# Masked Program Memory Checksum Engine

The engine produces a 16-bit verification checksum of a microcontroller's program image. After a start request it walks the code memory from word address zero up to a parameterised end address, stepping over even word addresses only. It then reads seven 16-bit configuration registers that sit at consecutive even addresses above a parameterised base. Every byte it reads goes into a 16-bit accumulator that wraps.

A code word gives all three of its bytes. A configuration register gives only its lower 16 bits, after that value is ANDed with a fixed mask chosen by the register's position. The engine issues one read per cycle on a synchronous read port whose data returns one cycle later. It reports the finished sum through a done pulse and a held result register. If the code-protect input is high when the run finishes, the stored result is zero.

Top module: `prog_cksum_engine`

## Requirements
- R1: Each code word read adds its three bytes (bits 7:0, 15:8 and 23:16) to the accumulator as separate 8-bit values.
- R2: One run reads word addresses 0, 2, 4 … CODE_END (0x580 words by default), then addresses CFG_BASE + 2·k for k = 0 to 6 in ascending k, and performs no other reads.
- R3: Configuration register k adds only the two bytes of (bits 15:0 AND mask_k), with mask_k = 0x0003, 0x0087, 0x00DF, 0x00DF, 0x00FB, 0x00C3, 0x00FF for k = 0..6. Bits 23:16 of the read data are ignored.
- R4: Every addition wraps modulo 2^16.
- R5: If code_protect is high in the cycle before done pulses, the stored result is 0x0000.
- R6: With all code words erased to 0xFFFFFF, writing 0xAAAAAA at the first and at the last code word lowers the result by exactly 0x01FE.
- R7: Reads are issued back to back, one per cycle, with a one-cycle data latency, so done is seen 1417 cycles after the clock edge that accepts start.
- R8: A start request while busy is high has no effect on the running sum, the read sequence or the timing.
- R9: Done is high for a single cycle. Busy falls in that same cycle. The result holds its value until the next done pulse.
- R10: A synchronous active-high reset clears busy, done, the result and the read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a checksum run (accepted only when idle) |
| code_protect | input | 1 | Forces the stored result to zero at completion |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| checksum | output | 16 | Held checksum result |
| mem_rd_en | output | 1 | Read strobe to the memory |
| mem_addr | output | 24 | Word address of the read |
| mem_rdata | input | 24 | Read data, valid one cycle after the strobe |

## Verification
The bench places junk in the upper bits of the configuration read data and changes only those bits between two runs. A design that let them through, or that applied a mask to the wrong position, would give different sums. A random code image carries the total past 2^16 many times, so an adder that does not wrap or that drops a byte lane gives a wrong value. A start pulse in the middle of a run checks that the engine does not restart or clear its accumulator. The read address log and the exact done latency catch a skipped word, a repeated word, or a stall in the read pipeline. The erased and edge-pattern images must differ by 0x01FE. Raising code_protect on one run must give zero, and the next run without it must again give the full sum.

// File: rtl/pmck_pkg.sv
package pmck_pkg;
   localparam int CFG_COUNT = 7;

   typedef enum logic [0:0] {SRC_CODE = 1'b0, SRC_CFG = 1'b1} src_e;

   function automatic logic [15:0] cfg_mask(input logic [2:0] sel);
      logic [15:0] m;
      case (sel)
         3'd0:    m = 16'h0003;
         3'd1:    m = 16'h0087;
         3'd2:    m = 16'h00DF;
         3'd3:    m = 16'h00DF;
         3'd4:    m = 16'h00FB;
         3'd5:    m = 16'h00C3;
         3'd6:    m = 16'h00FF;
         default: m = 16'h0000;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/pmck_addr_seq.sv
module pmck_addr_seq
   import pmck_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int ADDR_STEP = 2,
   parameter int CODE_END  = 'h0AFE,
   parameter int CFG_BASE  = 'hF80000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              fin,
   output logic              busy,
   output logic              accept,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output src_e              rd_src,
   output logic [2:0]        rd_sel,
   output logic              rd_last
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(ADDR_STEP);
   localparam logic [ADDR_W-1:0] END_V  = ADDR_W'(CODE_END);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(CFG_BASE);

   logic              issuing;
   src_e              src;
   logic [ADDR_W-1:0] code_addr;
   logic [2:0]        cfg_idx;

   assign accept  = start & ~busy;
   assign rd_en   = issuing;
   assign rd_src  = src;
   assign rd_sel  = cfg_idx;
   assign rd_last = (src == SRC_CFG) && (cfg_idx == 3'(CFG_COUNT - 1));
   assign rd_addr = (src == SRC_CODE) ? code_addr
                                      : BASE_V + ADDR_W'(cfg_idx) * STEP_V;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy      <= 1'b0;
         issuing   <= 1'b0;
         src       <= SRC_CODE;
         code_addr <= '0;
         cfg_idx   <= '0;
      end else if (accept) begin
         busy      <= 1'b1;
         issuing   <= 1'b1;
         src       <= SRC_CODE;
         code_addr <= '0;
         cfg_idx   <= '0;
      end else begin
         if (fin) busy <= 1'b0;
         if (issuing) begin
            if (src == SRC_CODE) begin
               if (code_addr == END_V) src <= SRC_CFG;
               else                    code_addr <= code_addr + STEP_V;
            end else if (rd_last) begin
               issuing <= 1'b0;
            end else begin
               cfg_idx <= cfg_idx + 3'd1;
            end
         end
      end
   end

   // R8
   busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !fin) |=> busy);
   // R2
   no_read_idle_chk: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> busy);
endmodule

// File: rtl/pmck_byte_sum.sv
module pmck_byte_sum
   import pmck_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int CFG_W  = 16,
   parameter int SUM_W  = 16
) (
   input  logic [DATA_W-1:0] data,
   input  src_e              src,
   input  logic [2:0]        sel,
   output logic [SUM_W-1:0]  contrib
);
   localparam int CODE_BYTES = DATA_W / 8;
   localparam int CFG_BYTES  = CFG_W / 8;

   logic [7:0]       code_b [CODE_BYTES];
   logic [7:0]       cfg_b  [CFG_BYTES];
   logic [CFG_W-1:0] masked;

   assign masked = data[CFG_W-1:0] & CFG_W'(cfg_mask(sel));

   for (genvar i = 0; i < CODE_BYTES; i++) begin : g_code_lane
      assign code_b[i] = data[8*i +: 8];
   end
   for (genvar j = 0; j < CFG_BYTES; j++) begin : g_cfg_lane
      assign cfg_b[j] = masked[8*j +: 8];
   end

   logic [SUM_W-1:0] code_sum, cfg_sum;
   always_comb begin
      code_sum = '0;
      for (int i = 0; i < CODE_BYTES; i++) code_sum = code_sum + SUM_W'(code_b[i]);
      cfg_sum = '0;
      for (int j = 0; j < CFG_BYTES; j++) cfg_sum = cfg_sum + SUM_W'(cfg_b[j]);
   end

   assign contrib = (src == SRC_CODE) ? code_sum : cfg_sum;
endmodule

// File: rtl/pmck_accum.sv
module pmck_accum #(
   parameter int SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             valid,
   input  logic             last,
   input  logic [SUM_W-1:0] contrib,
   input  logic             protect,
   output logic             done,
   output logic [SUM_W-1:0] result
);
   logic [SUM_W-1:0] acc, acc_nx;
   assign acc_nx = acc + contrib;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc    <= '0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         if (clear) begin
            acc <= '0;
         end else if (valid) begin
            acc <= acc_nx;
            if (last) begin
               done   <= 1'b1;
               result <= protect ? '0 : acc_nx;
            end
         end
      end
   end

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(valid && last) |=> $stable(result));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

// File: rtl/prog_cksum_engine.sv
module prog_cksum_engine
   import pmck_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 24,
   parameter int CFG_W     = 16,
   parameter int SUM_W     = 16,
   parameter int ADDR_STEP = 2,
   parameter int CODE_END  = 'h0AFE,
   parameter int CFG_BASE  = 'hF80000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              code_protect,
   output logic              busy,
   output logic              done,
   output logic [SUM_W-1:0]  checksum,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (DATA_W % 8 != 0 || CFG_W % 8 != 0 || CFG_W > DATA_W) begin : g_bad_width
      $error("data and config widths must be whole bytes, config not wider than data");
   end
   if (ADDR_STEP < 1 || CODE_END % ADDR_STEP != 0) begin : g_bad_step
      $error("code end address must be a multiple of the address step");
   end
   if (CFG_BASE <= CODE_END) begin : g_bad_base
      $error("config base must lie above the code range");
   end

   logic       accept, fin;
   src_e       rd_src, src_q;
   logic [2:0] rd_sel, sel_q;
   logic       rd_last, valid_q, last_q;
   logic [SUM_W-1:0] contrib;

   pmck_addr_seq #(
      .ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP),
      .CODE_END(CODE_END), .CFG_BASE(CFG_BASE)
   ) i_seq (
      .clk(clk), .rst(rst), .start(start), .fin(fin),
      .busy(busy), .accept(accept), .rd_en(mem_rd_en), .rd_addr(mem_addr),
      .rd_src(rd_src), .rd_sel(rd_sel), .rd_last(rd_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         last_q  <= 1'b0;
         src_q   <= SRC_CODE;
         sel_q   <= '0;
      end else begin
         valid_q <= mem_rd_en;
         last_q  <= mem_rd_en & rd_last;
         src_q   <= rd_src;
         sel_q   <= rd_sel;
      end
   end

   assign fin = valid_q & last_q;

   pmck_byte_sum #(.DATA_W(DATA_W), .CFG_W(CFG_W), .SUM_W(SUM_W)) i_bytes (
      .data(mem_rdata), .src(src_q), .sel(sel_q), .contrib(contrib)
   );

   pmck_accum #(.SUM_W(SUM_W)) i_acc (
      .clk(clk), .rst(rst), .clear(accept), .valid(valid_q), .last(last_q),
      .contrib(contrib), .protect(code_protect), .done(done), .result(checksum)
   );

   // R5
   protect_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (done && $past(code_protect)) |-> (checksum == '0));
   // R9
   busy_falls_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   // R2
   addr_range_chk: assert property (@(posedge clk) disable iff (rst)
      mem_rd_en |-> (mem_addr <= ADDR_W'(CODE_END) || mem_addr >= ADDR_W'(CFG_BASE)));
   // R7
   no_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_rd_en && !rd_last) |=> mem_rd_en);
endmodule

// File: tb/test_prog_cksum_engine.sv
module test_prog_cksum_engine;
   localparam int NCODE = 'h580;
   localparam int NREAD = NCODE + 7;
   localparam int LAT   = NREAD + 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        code_protect = 1'b0;
   logic        busy, done, mem_rd_en;
   logic [15:0] checksum;
   logic [23:0] mem_addr;
   logic [23:0] mem_rdata = '0;

   logic [23:0] code_mem [NCODE];
   logic [23:0] cfg_mem  [7];
   int checks = 0, failures = 0;
   int rd_cnt = 0, addr_err = 0;

   always #2 clk = ~clk;

   prog_cksum_engine i_prog_cksum_engine (
      .clk(clk), .rst(rst), .start(start), .code_protect(code_protect),
      .busy(busy), .done(done), .checksum(checksum),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_rd_en) begin
         int exp_a;
         exp_a = (rd_cnt < NCODE) ? rd_cnt * 2 : 'hF80000 + (rd_cnt - NCODE) * 2;
         if (int'(mem_addr) != exp_a) addr_err++;
         rd_cnt++;
         if (mem_addr >= 24'hF80000) mem_rdata <= cfg_mem[(mem_addr - 24'hF80000) >> 1];
         else                        mem_rdata <= code_mem[mem_addr >> 1];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] model();
      logic [15:0] s, m;
      logic [15:0] mk [7];
      mk = '{16'h0003, 16'h0087, 16'h00DF, 16'h00DF, 16'h00FB, 16'h00C3, 16'h00FF};
      s = 0;
      for (int i = 0; i < NCODE; i++)
         s = s + 16'(code_mem[i][7:0]) + 16'(code_mem[i][15:8]) + 16'(code_mem[i][23:16]);
      for (int k = 0; k < 7; k++) begin
         m = cfg_mem[k][15:0] & mk[k];
         s = s + 16'(m[7:0]) + 16'(m[15:8]);
      end
      return s;
   endfunction

   task automatic fill(input bit erased, input int seed);
      logic [31:0] x = 32'(seed) | 32'h1;
      for (int i = 0; i < NCODE; i++) begin
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         code_mem[i] = erased ? 24'hFFFFFF : x[23:0];
      end
      for (int k = 0; k < 7; k++) begin
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         cfg_mem[k] = erased ? 24'h00FFFF : x[23:0];
      end
   endtask

   task automatic run(input logic prot, input bit poke, output logic [15:0] res);
      int lat;
      logic [15:0] held;
      rd_cnt = 0; addr_err = 0;
      @(negedge clk); code_protect = prot; start = 1'b1;
      @(negedge clk); start = 1'b0; lat = 1;
      chk("R8 busy after start", {31'd0, busy}, 1);
      while (!done && lat < 5000) begin
         start = (poke && lat == 100);
         @(negedge clk); lat++;
      end
      start = 1'b0;
      res = checksum;
      chk("R7 done latency", lat, LAT);
      chk("R9 busy low at done", {31'd0, busy}, 0);
      chk("R2 read count", rd_cnt, NREAD);
      chk("R2 read order", addr_err, 0);
      held = checksum;
      @(negedge clk);
      chk("R9 done one cycle", {31'd0, done}, 0);
      repeat (5) @(negedge clk);
      chk("R9 result held", {16'd0, checksum}, {16'd0, held});
      code_protect = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 busy reset", {31'd0, busy}, 0);
      chk("R10 done reset", {31'd0, done}, 0);
      chk("R10 checksum reset", {16'd0, checksum}, 0);
      chk("R10 rd_en reset", {31'd0, mem_rd_en}, 0);
   endtask

   task automatic t_vectors();
      logic [15:0] r_erased, r_edge;
      fill(1, 1);
      run(0, 0, r_erased);
      chk("R1 erased image", {16'd0, r_erased}, {16'd0, model()});
      code_mem[0] = 24'hAAAAAA; code_mem[NCODE-1] = 24'hAAAAAA;
      run(0, 0, r_edge);
      chk("R6 edge pattern delta", {16'd0, r_edge}, {16'd0, 16'(r_erased - 16'h01FE)});
   endtask

   task automatic t_random_wrap();
      logic [15:0] r;
      fill(0, 32'h1234567);
      run(0, 0, r);
      chk("R4 random image wrap", {16'd0, r}, {16'd0, model()});
   endtask

   task automatic t_cfg_upper();
      logic [15:0] r1, r2;
      fill(0, 77);
      for (int k = 0; k < 7; k++) cfg_mem[k][23:16] = 8'h00;
      run(0, 0, r1);
      chk("R3 config masked", {16'd0, r1}, {16'd0, model()});
      for (int k = 0; k < 7; k++) cfg_mem[k][23:16] = 8'hC5 + 8'(k);
      run(0, 0, r2);
      chk("R3 upper bits ignored", {16'd0, r2}, {16'd0, r1});
   endtask

   task automatic t_protect();
      logic [15:0] r;
      fill(0, 999);
      run(1, 0, r);
      chk("R5 protected result", {16'd0, r}, 0);
      run(0, 0, r);
      chk("R5 unprotected again", {16'd0, r}, {16'd0, model()});
   endtask

   task automatic t_start_busy();
      logic [15:0] r;
      fill(0, 4242);
      run(0, 1, r);
      chk("R8 start while busy ignored", {16'd0, r}, {16'd0, model()});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_vectors();
      t_random_wrap();
      t_cfg_upper();
      t_protect();
      t_start_busy();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule